// File: doc/BRIEF.md
# Boot ROM Read Overlay

This block sits between a processor read port and a boot ROM. When it is enabled, it intercepts reads that land in either of two 4 KiB address windows, one at the top of the 32-bit space and one just above 64 KiB. An instruction fetch in either window gets one fixed opcode back. That opcode loads the program counter from a literal placed 0x18 bytes past the fetch address plus eight. A data read in the same windows returns a programmable entry address. The combined effect is that any core booting from the ROM jumps to the entry address that software wrote into the block.

All other reads, and every read while the block is disabled, go to the ROM unchanged. The ROM is modelled as having one cycle of synchronous read latency. The block makes its overlay decision in the request cycle and registers it next to the ROM's own output register. Read data therefore appears one cycle after the request, whatever the source. For intercepted reads the ROM enable is held low, so the ROM is not accessed.

A small configuration port holds an enable bit and the entry address register. Both can be read back.

Top module: `boot_ovl_top`

## Requirements
- R1: After a synchronous reset, the enable bit reads 0, the entry address reads 0, and `rvalid` is 0.
- R2: A write with `cfg_addr`=0 stores `cfg_wdata[0]` as the enable bit. Reading `cfg_addr`=0 returns the enable bit in bit 0 and zeros in all higher bits.
- R3: A write with `cfg_addr`=1 stores the entry address with bits [1:0] forced to 0. Reading `cfg_addr`=1 returns the stored value.
- R4: An enabled read hits when its address is in 0xFFFF0000–0xFFFF0FFF or in 0x00010000–0x00010FFF. Addresses one word below or above either window are not intercepted.
- R5: An instruction fetch (`rd_fetch`=1) that hits returns 0xE59FF018.
- R6: A data read (`rd_fetch`=0) that hits returns the entry address as it stood in the request cycle.
- R7: While the enable bit is 0, every read returns the ROM word at its address, including reads inside the windows.
- R8: For a read that is not intercepted, `rom_en` is 1 and `rom_addr` equals `rd_addr` in the request cycle. For a hit, `rom_en` is 0.
- R9: `rvalid` rises exactly one cycle after each request cycle and is 0 one cycle after a cycle with no request.
- R10: A configuration write in the same cycle as a read does not affect that read. It applies from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | Register select: 0 enable, 1 entry address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| rd_valid | input | 1 | Read request |
| rd_addr | input | 32 | Read byte address |
| rd_fetch | input | 1 | 1 = instruction fetch, 0 = data read |
| rom_en | output | 1 | ROM read enable |
| rom_addr | output | 32 | ROM read address |
| rom_rdata | input | 32 | ROM read data, one cycle after `rom_en` |
| rvalid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and data, two windows of 2^12 bytes, and an alignment mask of two bits. With these values the exact window edges are in reach: the first and last word of each window, and the words just outside them. The full-width address also lets the bench confirm that the upper window does not wrap into address 0. The bench's ROM returns a word derived from its address, so a passed-through read is told apart from an overlay word for every address it uses.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  typedef enum logic {
    CFG_SEL_CTRL  = 1'b0,
    CFG_SEL_ENTRY = 1'b1
  } cfg_sel_e;

  localparam logic [31:0] BRANCH_OPCODE = 32'hE59FF018;
endpackage

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs #(
  parameter int DW         = 32,
  parameter int ALIGN_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          en,
  output logic [DW-1:0] entry
);
  import boot_ovl_pkg::*;

  localparam logic [DW-1:0] ALIGN_MASK = ~((DW)'((1 << ALIGN_BITS) - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      entry <= '0;
    end else if (we) begin
      if (cfg_sel_e'(sel) == CFG_SEL_CTRL) en <= wdata[0];
      else                                 entry <= wdata & ALIGN_MASK;
    end
  end

  always_comb begin
    if (cfg_sel_e'(sel) == CFG_SEL_CTRL) rdata = {{(DW-1){1'b0}}, en};
    else                                 rdata = entry;
  end
endmodule

// File: rtl/ovl_win_decode.sv
module ovl_win_decode #(
  parameter int                      AW        = 32,
  parameter int                      NUM_WIN   = 2,
  parameter int                      WIN_BITS  = 12,
  parameter logic [NUM_WIN*AW-1:0]   WIN_BASES = {32'h0001_0000, 32'hFFFF_0000}
) (
  input  logic [AW-1:0] addr,
  output logic          hit
);
  logic [NUM_WIN-1:0] win_hit;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam logic [AW-1:0] BASE = WIN_BASES[i*AW +: AW];
    logic [AW-1:0] diff;
    assign diff       = addr ^ BASE;
    assign win_hit[i] = ((diff >> WIN_BITS) == '0);
  end

  assign hit = |win_hit;
endmodule

// File: rtl/ovl_resp_stage.sv
module ovl_resp_stage #(
  parameter int          DW     = 32,
  parameter logic [31:0] OPCODE = 32'hE59FF018
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          take,
  input  logic          fetch,
  input  logic [DW-1:0] entry,
  input  logic [DW-1:0] rom_word,
  output logic          vld,
  output logic [DW-1:0] data
);
  logic          take_q;
  logic [DW-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld    <= 1'b0;
      take_q <= 1'b0;
      word_q <= '0;
    end else begin
      vld    <= req;
      take_q <= req & take;
      if (req & take) word_q <= fetch ? DW'(OPCODE) : entry;
    end
  end

  assign data = take_q ? word_q : rom_word;
endmodule

// File: rtl/boot_ovl_top.sv
module boot_ovl_top #(
  parameter int                    AW         = 32,
  parameter int                    DW         = 32,
  parameter int                    NUM_WIN    = 2,
  parameter int                    WIN_BITS   = 12,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASES  = {32'h0001_0000, 32'hFFFF_0000},
  parameter int                    ALIGN_BITS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic          cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_fetch,
  output logic          rom_en,
  output logic [AW-1:0] rom_addr,
  input  logic [DW-1:0] rom_rdata,
  output logic          rvalid,
  output logic [DW-1:0] rd_data
);
  import boot_ovl_pkg::*;

  logic          ovl_en;
  logic [DW-1:0] ovl_entry;
  logic          win_hit;
  logic          take;

  ovl_cfg_regs #(.DW(DW), .ALIGN_BITS(ALIGN_BITS)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_addr), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .en(ovl_en), .entry(ovl_entry)
  );

  ovl_win_decode #(.AW(AW), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS),
                   .WIN_BASES(WIN_BASES)) u_dec (
    .addr(rd_addr), .hit(win_hit)
  );

  assign take     = ovl_en & win_hit;
  assign rom_en   = rd_valid & ~take;
  assign rom_addr = rd_addr;

  ovl_resp_stage #(.DW(DW), .OPCODE(BRANCH_OPCODE)) u_resp (
    .clk(clk), .rst(rst), .req(rd_valid), .take(take), .fetch(rd_fetch),
    .entry(ovl_entry), .rom_word(rom_rdata), .vld(rvalid), .data(rd_data)
  );
endmodule

// File: rtl/boot_ovl_chk.sv
module boot_ovl_chk #(
  parameter int                    AW        = 32,
  parameter int                    DW        = 32,
  parameter int                    NUM_WIN   = 2,
  parameter int                    WIN_BITS  = 12,
  parameter logic [NUM_WIN*AW-1:0] WIN_BASES = {32'h0001_0000, 32'hFFFF_0000}
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_addr,
  input logic [DW-1:0] cfg_rdata,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_fetch,
  input logic          rom_en,
  input logic [AW-1:0] rom_addr,
  input logic          rvalid,
  input logic [DW-1:0] rd_data,
  input logic          ovl_en,
  input logic [DW-1:0] ovl_entry
);
  logic in_win;
  always_comb begin
    in_win = 1'b0;
    for (int i = 0; i < NUM_WIN; i++)
      if ((rd_addr >> WIN_BITS) == (WIN_BASES[i*AW +: AW] >> WIN_BITS)) in_win = 1'b1;
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!rvalid && !ovl_en && ovl_entry == '0));

  p_ctrl_read_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_addr == 1'b0) |-> (cfg_rdata[DW-1:1] == '0));

  p_entry_align_r3: assert property (@(posedge clk) disable iff (rst)
    ovl_entry[1:0] == 2'b00);

  p_fetch_word_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ovl_en && in_win && rd_fetch) |=> (rd_data == 32'hE59FF018));

  p_data_word_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ovl_en && in_win && !rd_fetch) |=> (rd_data == $past(ovl_entry)));

  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !ovl_en) |-> (rom_en && rom_addr == rd_addr));

  p_rom_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && ovl_en && in_win) |-> !rom_en);

  p_req_lat_r9: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rvalid);

  p_idle_lat_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |=> !rvalid);
endmodule

bind boot_ovl_top boot_ovl_chk #(
  .AW(AW), .DW(DW), .NUM_WIN(NUM_WIN), .WIN_BITS(WIN_BITS), .WIN_BASES(WIN_BASES)
) u_chk (
  .clk(clk), .rst(rst), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_fetch(rd_fetch),
  .rom_en(rom_en), .rom_addr(rom_addr), .rvalid(rvalid), .rd_data(rd_data),
  .ovl_en(ovl_en), .ovl_entry(ovl_entry)
);

// File: tb/boot_ovl_top_tb.sv
module boot_ovl_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic        cfg_addr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_fetch = 1'b0;
  logic        rom_en;
  logic [31:0] rom_addr;
  logic [31:0] rom_rdata = '0;
  logic        rvalid;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_en = 1'b0;
  logic [31:0] m_entry = '0;

  always #5 clk = ~clk;

  boot_ovl_top u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_valid(rd_valid),
    .rd_addr(rd_addr), .rd_fetch(rd_fetch), .rom_en(rom_en),
    .rom_addr(rom_addr), .rom_rdata(rom_rdata), .rvalid(rvalid), .rd_data(rd_data)
  );

  function automatic logic [31:0] rom_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) if (rom_en) rom_rdata <= rom_word(rom_addr);

  function automatic bit in_window(input logic [31:0] a);
    return (a >= 32'hFFFF_0000 && a <= 32'hFFFF_0FFF) ||
           (a >= 32'h0001_0000 && a <= 32'h0001_0FFF);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] a, input bit f,
                      input bit we, input bit wa, input logic [31:0] wd,
                      input string tag);
    bit hit;
    logic [31:0] exp;
    rd_valid = v; rd_addr = a; rd_fetch = f;
    cfg_we = we; cfg_addr = wa; cfg_wdata = wd;
    #1;
    hit = v && m_en && in_window(a);
    check({tag, " rom_en R8"}, {31'b0, rom_en}, {31'b0, v && !hit});
    if (v && !hit) check({tag, " rom_addr R8"}, rom_addr, a);
    check(wa ? "cfg readback R3" : "cfg readback R2", cfg_rdata,
          wa ? m_entry : {31'b0, m_en});
    exp = hit ? (f ? 32'hE59FF018 : m_entry) : rom_word(a);
    @(posedge clk);
    if (we) begin
      if (wa) m_entry = wd & 32'hFFFF_FFFC;
      else    m_en    = wd[0];
    end
    @(negedge clk);
    check({tag, " rvalid R9"}, {31'b0, rvalid}, {31'b0, v});
    if (v) check({tag, " data"}, rd_data, exp);
    rd_valid = 1'b0; cfg_we = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cfg_addr = 1'b0; #1;
    check("reset enable R1", cfg_rdata, 32'h0);
    check("reset rvalid R1", {31'b0, rvalid}, 32'h0);
    cfg_addr = 1'b1; #1;
    check("reset entry R1", cfg_rdata, 32'h0);
    @(negedge clk);

    // R7: disabled, window reads pass through
    step(1, 32'hFFFF_0000, 1, 0, 0, 0, "R7 disabled fetch");
    step(1, 32'h0001_0010, 0, 0, 0, 0, "R7 disabled data");
    step(0, 0, 0, 0, 0, 0, "R9 idle");

    // R3: entry write forces low bits
    step(0, 0, 0, 1, 1, 32'h1234_5677, "R3 entry write");
    step(0, 0, 0, 0, 1, 0, "R3 entry readback");
    // R2: only bit 0 kept
    step(0, 0, 0, 1, 0, 32'hFFFF_FFFF, "R2 enable write");
    step(0, 0, 0, 0, 0, 0, "R2 enable readback");

    // R5 / R4: fetches at window edges
    step(1, 32'hFFFF_0000, 1, 0, 0, 0, "R5 R4 top low edge");
    step(1, 32'hFFFF_0FFC, 1, 0, 0, 0, "R5 R4 top high edge");
    step(1, 32'h0001_0000, 1, 0, 0, 0, "R5 R4 low window start");
    step(1, 32'h0001_0FFF, 1, 0, 0, 0, "R5 R4 low window end");
    // R6: data reads
    step(1, 32'hFFFF_0018, 0, 0, 0, 0, "R6 data top");
    step(1, 32'h0001_0020, 0, 0, 0, 0, "R6 data low");
    // R4: just outside
    step(1, 32'hFFFE_FFFC, 1, 0, 0, 0, "R4 below top");
    step(1, 32'hFFFF_1000, 1, 0, 0, 0, "R4 above top");
    step(1, 32'h0000_FFFC, 0, 0, 0, 0, "R4 below low");
    step(1, 32'h0001_1000, 0, 0, 0, 0, "R4 above low");
    step(1, 32'h0000_0000, 1, 0, 0, 0, "R4 no wrap at zero");

    // R10: write in same cycle as read
    step(1, 32'h0001_0004, 0, 1, 1, 32'hCAFE_BABE, "R10 same-cycle entry");
    step(1, 32'h0001_0004, 0, 0, 1, 0, "R10 new entry");
    step(1, 32'hFFFF_0008, 1, 1, 0, 32'h0, "R10 same-cycle disable");
    step(1, 32'hFFFF_0008, 1, 0, 0, 0, "R10 R7 after disable");
    // back-to-back requests, re-enable
    step(0, 0, 0, 1, 0, 32'h1, "R2 re-enable");
    for (int i = 0; i < 8; i++)
      step(1, (i % 2) ? 32'h0001_0000 + 32'(i*4) : 32'h0000_2000 + 32'(i*4),
           i[2], 0, 0, 0, "R9 stream");
    step(0, 0, 0, 0, 0, 0, "R9 idle end");

    // R1: reset again clears state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; m_en = 1'b0; m_entry = '0;
    check("rerun rvalid R1", {31'b0, rvalid}, 32'h0);
    step(0, 0, 0, 0, 1, 0, "R1 entry cleared");
    step(1, 32'hFFFF_0000, 1, 0, 0, 0, "R1 R7 disabled after reset");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule